// File: doc/BRIEF.md
# Miss-Triggered Line Prefetch Generator

This block sits next to a cache controller and turns each demand miss into a short burst of extra line-fill requests, so that nearby lines are on their way before the program asks for them. The cache reports a miss by pulsing `miss_valid_i` with the byte address that missed, and the block then offers the extra line addresses one at a time on a valid/ready channel. Every request it offers carries a prefetch tag, so the cache can mark the filled lines and keep its prefetch statistics apart from its demand statistics.

Two modes are supported and are picked per miss. In run-ahead mode the block asks for a programmed number of lines that follow the missing one. For example, a first-level cache might use one line and a second-level cache four. In pair mode it asks only for the partner line that completes the naturally aligned two-line block holding the miss. A fresh miss always takes over from whatever burst is still pending.

Top module: `prefetch_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_valid_o` is 0.
- R2: Every request address has its six low bits (byte offset within a 64-byte line) at zero, whatever the offset of the missing address.
- R3: With `pf_mode_i` = 0 (run-ahead) and `pf_count_i` = N, a miss at line base L yields exactly N requests with addresses L+64, L+128, ... L+64*N, in that order. The first request is valid in the cycle after the miss is sampled, and each later one follows in the cycle after the one before it is accepted.
- R4: In run-ahead mode with `pf_count_i` = 0, a miss yields no request.
- R5: In run-ahead mode a `pf_count_i` above `MAX_PF` (default 8) is treated as `MAX_PF`.
- R6: With `pf_mode_i` = 1 (pair), a miss at line base L yields exactly one request at L with address bit 6 inverted, and `pf_count_i` is ignored.
- R7: While `req_valid_o` is 1 and `req_ready_i` is 0, with no new miss, the request stays valid and its address does not change.
- R8: A miss that arrives while a burst is pending drops the rest of that burst. The next request belongs to the new miss.
- R9: Every request is offered with `req_pf_o` = 1.
- R10: Run-ahead addresses wrap modulo 2^ADDR_W (32 bits by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid_i | input | 1 | One-cycle pulse: a demand miss occurred |
| miss_addr_i | input | ADDR_W | Byte address of the demand miss |
| pf_mode_i | input | 1 | 0 = run-ahead lines, 1 = aligned pair partner |
| pf_count_i | input | CNT_W | Number of run-ahead lines, sampled with the miss |
| req_valid_o | output | 1 | A prefetch request is offered |
| req_ready_i | input | 1 | The cache accepts the offered request |
| req_addr_o | output | ADDR_W | Line-aligned byte address of the request |
| req_pf_o | output | 1 | Prefetch tag for the offered request |

## Verification
The assertions check the per-cycle rules on every clock: offset bits are zero, the tag is present, a stalled request holds its address, the block stays quiet without a miss, and accepted run-ahead requests advance by one line. Only the bench scenarios can show the length and content of each burst. That covers the exact count for each mode, the zero count, the clamping of oversized counts, the pair partner in both halves of the aligned block, wrap-around at the top of the address space, and a burst cut short by a new miss.

// File: rtl/pfg_pkg.sv
// Package: shared types of the prefetch generator.
// Assumes nothing beyond a single clock domain.
package pfg_pkg;
    typedef enum logic {
        PF_MODE_RUN  = 1'b0,   // request lines that follow the miss
        PF_MODE_PAIR = 1'b1    // request the partner in the aligned pair
    } pf_mode_e;
endpackage

// File: rtl/pfg_line_math.sv
// Module: pfg_line_math
// Pure address arithmetic. It aligns a miss to its line, forms the pair
// partner, the first run-ahead line and the step after the current line.
// Assumes LINE_BYTES is a power of two and smaller than 2^ADDR_W.
module pfg_line_math #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] line_base,
    output logic [ADDR_W-1:0] pair_addr,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] step_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_INC = ADDR_W'(LINE_BYTES);

    // Address arithmetic for line alignment, pair partner and increment.
    always_comb begin
        line_base  = {miss_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        pair_addr  = line_base ^ LINE_INC;
        first_addr = line_base + LINE_INC;
        step_addr  = cur_addr + LINE_INC;
    end
endmodule

// File: rtl/pfg_seq_ctrl.sv
// Module: pfg_seq_ctrl
// Holds the pending burst: the current request address and the number of
// requests still to issue. A start always overrides the running burst.
// Assumes start_len never exceeds what REM_W bits can hold.
module pfg_seq_ctrl #(
    parameter int ADDR_W = 32,
    parameter int REM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [REM_W-1:0]  start_len,
    input  logic              fire,
    input  logic [ADDR_W-1:0] step_addr,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [REM_W-1:0] remain;

    // Load a new burst on start, otherwise count down on each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain   <= '0;
            cur_addr <= '0;
        end else if (start) begin
            busy     <= (start_len != '0);
            remain   <= start_len;
            cur_addr <= start_addr;
        end else if (fire) begin
            remain   <= remain - 1'b1;
            cur_addr <= step_addr;
            if (remain == REM_W'(1)) busy <= 1'b0;
        end
    end

    // R3: an active burst always has at least one request left.
    p_busy_has_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain != '0));

    // R4: a start with zero length leaves the block idle.
    p_zero_len_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_len == '0) |=> !busy);
endmodule

// File: rtl/prefetch_gen.sv
// Module: prefetch_gen (top)
// Turns each demand miss into a burst of tagged line prefetch requests on
// a valid/ready channel, in run-ahead or aligned-pair mode.
// Assumes miss_valid_i is a one-cycle pulse per miss. Mode and count are
// sampled in the same cycle as the miss.
module prefetch_gen #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_PF     = 8,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid_i,
    input  logic [ADDR_W-1:0] miss_addr_i,
    input  logic              pf_mode_i,
    input  logic [CNT_W-1:0]  pf_count_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              req_pf_o
);
    import pfg_pkg::*;

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int REM_W = $clog2(MAX_PF + 1);

    pf_mode_e          mode;
    logic [ADDR_W-1:0] line_base, pair_addr, first_addr, step_addr, cur_addr;
    logic [ADDR_W-1:0] start_addr;
    logic [REM_W-1:0]  start_len;
    logic              busy, fire;

    pfg_line_math #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_math (
        .miss_addr (miss_addr_i),
        .cur_addr  (cur_addr),
        .line_base (line_base),
        .pair_addr (pair_addr),
        .first_addr(first_addr),
        .step_addr (step_addr)
    );

    // Pick the first address and burst length for the selected mode.
    always_comb begin
        mode = pf_mode_e'(pf_mode_i);
        if (mode == PF_MODE_PAIR) begin
            start_addr = pair_addr;
            start_len  = REM_W'(1);
        end else begin
            start_addr = first_addr;
            if (pf_count_i > CNT_W'(MAX_PF)) start_len = REM_W'(MAX_PF);
            else                             start_len = REM_W'(pf_count_i);
        end
    end

    pfg_seq_ctrl #(.ADDR_W(ADDR_W), .REM_W(REM_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (miss_valid_i),
        .start_addr(start_addr),
        .start_len (start_len),
        .fire      (fire),
        .step_addr (step_addr),
        .busy      (busy),
        .cur_addr  (cur_addr)
    );

    // Drive the request channel from the burst state.
    always_comb begin
        fire        = busy && req_ready_i;
        req_valid_o = busy;
        req_addr_o  = cur_addr;
        req_pf_o    = busy;
    end

    // R2: offered addresses are line aligned.
    p_line_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_addr_o[OFF_W-1:0] == '0));

    // R9: every offered request carries the prefetch tag.
    p_pf_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> req_pf_o);

    // R7: a stalled request keeps its address until accepted.
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i && !miss_valid_i)
            |=> (req_valid_o && $stable(req_addr_o)));

    // R3: after an accept with no miss, the next request is one line on.
    p_step_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i && !miss_valid_i)
            |=> (!req_valid_o || req_addr_o == $past(req_addr_o) + ADDR_W'(LINE_BYTES)));

    // R1: with no request and no miss, the channel stays idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid_o && !miss_valid_i) |=> !req_valid_o);
endmodule

// File: tb/prefetch_gen_tb_top.sv
`timescale 1ns/1ps
module prefetch_gen_tb_top;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              miss_valid_i;
    logic [ADDR_W-1:0] miss_addr_i;
    logic              pf_mode_i;
    logic [3:0]        pf_count_i;
    logic              req_valid_o;
    logic              req_ready_i;
    logic [ADDR_W-1:0] req_addr_o;
    logic              req_pf_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    prefetch_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid_i(miss_valid_i), .miss_addr_i(miss_addr_i),
        .pf_mode_i(pf_mode_i), .pf_count_i(pf_count_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .req_pf_o(req_pf_o)
    );

    typedef struct packed {
        logic        mode;
        logic [3:0]  cnt;
        logic [31:0] addr;
        logic [3:0]  n;
        logic [31:0] first;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd1,  32'h1000_0013, 4'd1, 32'h1000_0040, 8'd3},  // R3 R2
        '{1'b0, 4'd4,  32'h0000_2FFF, 4'd4, 32'h0000_3000, 8'd3},  // R3
        '{1'b0, 4'd0,  32'h0000_5000, 4'd0, 32'h0000_0000, 8'd4},  // R4
        '{1'b0, 4'd15, 32'h0000_0100, 4'd8, 32'h0000_0140, 8'd5},  // R5
        '{1'b1, 4'd7,  32'h0000_0085, 4'd1, 32'h0000_00C0, 8'd6},  // R6 lower half
        '{1'b1, 4'd0,  32'h0000_00C7, 4'd1, 32'h0000_0080, 8'd6},  // R6 upper half
        '{1'b0, 4'd2,  32'hFFFF_FFC4, 4'd2, 32'h0000_0000, 8'd10}  // R10
    };

    task automatic check(input logic cond, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_miss(input logic m, input logic [3:0] c,
                              input logic [31:0] a, input logic rdy);
        @(negedge clk);
        miss_valid_i = 1'b1; pf_mode_i = m; pf_count_i = c;
        miss_addr_i = a; req_ready_i = rdy;
        @(negedge clk);
        miss_valid_i = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; miss_valid_i = 1'b0; miss_addr_i = '0;
        pf_mode_i = 1'b0; pf_count_i = '0; req_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        check(req_valid_o == 1'b0, "R1 in reset", {31'd0, req_valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_valid_o == 1'b0, "R1 after reset", {31'd0, req_valid_o}, 32'd0);

        // Table of vectors, walked by one loop.
        for (int v = 0; v < NV; v++) begin
            pulse_miss(VECS[v].mode, VECS[v].cnt, VECS[v].addr, 1'b1);
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                logic [31:0] e;
                e = VECS[v].first + 32'(i * 64);
                check(req_valid_o == 1'b1,
                      $sformatf("R%0d valid v%0d i%0d", VECS[v].req, v, i),
                      {31'd0, req_valid_o}, 32'd1);
                check(req_addr_o == e,
                      $sformatf("R%0d addr v%0d i%0d", VECS[v].req, v, i),
                      req_addr_o, e);
                check(req_pf_o == 1'b1, "R9 tag", {31'd0, req_pf_o}, 32'd1);
                @(negedge clk);
            end
            check(req_valid_o == 1'b0,
                  $sformatf("R%0d burst end v%0d", VECS[v].req, v),
                  {31'd0, req_valid_o}, 32'd0);
            @(negedge clk);
        end

        // R7: stall with ready low, address must hold.
        pulse_miss(1'b0, 4'd3, 32'h0000_4000, 1'b0);
        for (int k = 0; k < 3; k++) begin
            check(req_valid_o == 1'b1, "R7 held valid", {31'd0, req_valid_o}, 32'd1);
            check(req_addr_o == 32'h0000_4040, "R7 held addr", req_addr_o, 32'h0000_4040);
            @(negedge clk);
        end
        req_ready_i = 1'b1;
        @(negedge clk);
        check(req_addr_o == 32'h0000_4080, "R7 after release", req_addr_o, 32'h0000_4080);
        repeat (2) @(negedge clk);
        check(req_valid_o == 1'b0, "R7 burst end", {31'd0, req_valid_o}, 32'd0);

        // R8: a new miss mid-burst drops the remainder.
        pulse_miss(1'b0, 4'd4, 32'h0000_8000, 1'b1);
        check(req_addr_o == 32'h0000_8040, "R8 first old", req_addr_o, 32'h0000_8040);
        @(negedge clk);
        check(req_addr_o == 32'h0000_8080, "R8 second old", req_addr_o, 32'h0000_8080);
        pulse_miss(1'b0, 4'd1, 32'h0000_A000, 1'b0);
        check(req_addr_o == 32'h0000_A040, "R8 new burst", req_addr_o, 32'h0000_A040);
        req_ready_i = 1'b1;
        @(negedge clk);
        check(req_valid_o == 1'b0, "R8 old remainder dropped", {31'd0, req_valid_o}, 32'd0);
        repeat (3) @(negedge clk);
        check(req_valid_o == 1'b0, "R8 stays idle", {31'd0, req_valid_o}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule